// File: doc/BRIEF.md
# I/O Port Decoder with PCI Configuration Address Latch

This block sits behind a processor's I/O port instruction path and turns each port access into a routed physical address. One access per cycle enters with a port number, a byte count, a direction flag and write data. One cycle later the block presents a region code, the physical address that the access goes to, read data when the access targets the block's own register, and two flags: an error flag for a port number that does not fit in 16 bits and an unclaimed flag for a configuration data access that the latch does not enable.

The block holds the 32-bit configuration address latch of the legacy PCI configuration mechanism. A four-byte write to port 0xCF8 loads the latch, and a four-byte read returns it. Any access to ports 0xCFC through 0xCFF becomes a configuration-space access at the address held in the latch, but only while bit 31 of the latch is set. Every other 16-bit port goes to the general I/O region, with the port number placed in the low address bits.

Top module: `pci_port_decoder`

## Requirements
- R1: After synchronous reset, out_valid, out_err, out_unclaimed, out_region, out_addr and out_rdata are zero, and the configuration address latch holds zero, so a later four-byte read of port 0xCF8 returns 0.
- R2: An access whose port input has any bit above bit 15 set gives out_err=1, out_region=0 (none), out_addr=0, out_rdata=0 and changes no state.
- R3: A four-byte access (acc_size=4) to port 0xCF8 gives out_region=1 (latch) and out_addr=0. A write stores acc_wdata in the latch. A read returns the latch contents on out_rdata. A write returns 0 on out_rdata.
- R4: An access to port 0xCF8 with acc_size other than 4 goes to general I/O as in R7 and leaves the latch unchanged.
- R5: An access to a port p with (p & 0xFFFC)==0xCFC, while latch bit 31 is 1, gives out_region=2 (configuration space) and out_addr = (1<<(PA_W-1)) | latch[30:0]. The two low port bits do not change the address, and the latch is not written.
- R6: The same access while latch bit 31 is 0 gives out_unclaimed=1, out_region=0 and out_addr=0. A read returns all ones, and a write leaves the latch unchanged.
- R7: Any other 16-bit port p gives out_region=3 (general I/O) and out_addr = (1<<(PA_W-2)) | p, with out_rdata=0.
- R8: Results appear exactly one clock after the access. A cycle with acc_valid=0 gives out_valid=0 on the next clock and does not write the latch, whatever the other inputs are.
- R9: In a valid result, at most one of out_err, out_unclaimed and a non-zero out_region is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_port | input | PORT_IN_W | Port number, legal range 0..0xFFFF |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| out_valid | output | 1 | Result valid, one cycle after the access |
| out_region | output | 2 | 0 none, 1 latch, 2 configuration space, 3 general I/O |
| out_addr | output | PA_W | Routed physical address |
| out_rdata | output | 32 | Latch read data, or all ones for an unclaimed read |
| out_err | output | 1 | Port number exceeds 16 bits |
| out_unclaimed | output | 1 | Data window access while the latch is disabled |

## Verification
On every cycle the assertions check the following: the error flag follows an oversized port, idle cycles give no result, the result classes exclude each other, a latch write lands on the next edge, an unclaimed read returns all ones, and a configuration-space result only occurs while the enable bit was set. Only the bench scenarios can show that the exact address for each port is correct, that the low port bits are ignored in the data window, and that a non-four-byte access to 0xCF8 falls through to general I/O. They also show that dropped window writes and idle cycles leave the latch as it was, which the bench reads back through port 0xCF8.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    typedef enum logic [1:0] {
        RG_NONE   = 2'd0,
        RG_LATCH  = 2'd1,
        RG_CFGSPC = 2'd2,
        RG_GENIO  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        K_BADPORT = 2'd0,
        K_LATCH   = 2'd1,
        K_WINDOW  = 2'd2,
        K_GENIO   = 2'd3
    } kind_e;

    typedef struct packed {
        region_e     region;
        logic        err;
        logic        unclaimed;
        logic [31:0] rdata;
    } route_t;

    localparam logic [15:0] LATCH_PORT  = 16'h0CF8;
    localparam logic [15:0] WINDOW_BASE = 16'h0CFC;
    localparam logic [2:0]  LATCH_SIZE  = 3'd4;
    localparam int          LATCH_W     = 32;
    localparam int          EN_BIT      = 31;

    function automatic logic hits_window(input logic [15:0] p);
        return (p & 16'hFFFC) == WINDOW_BASE;
    endfunction

endpackage

// File: rtl/pcd_port_classifier.sv
module pcd_port_classifier
    import pcd_pkg::*;
#(
    parameter int PORT_IN_W = 32
) (
    input  logic [PORT_IN_W-1:0] port_in,
    input  logic [2:0]           size_in,
    output kind_e                kind,
    output logic [15:0]          port16
);
    logic too_wide;

    generate
        if (PORT_IN_W > 16) begin : g_hi
            assign too_wide = |port_in[PORT_IN_W-1:16];
            assign port16   = port_in[15:0];
        end else begin : g_lo
            assign too_wide = 1'b0;
            assign port16   = 16'(port_in);
        end
    endgenerate

    always_comb begin
        if (too_wide)
            kind = K_BADPORT;
        else if (port16 == LATCH_PORT && size_in == LATCH_SIZE)
            kind = K_LATCH;
        else if (hits_window(port16))
            kind = K_WINDOW;
        else
            kind = K_GENIO;
    end

endmodule

// File: rtl/pcd_cfg_latch.sv
module pcd_cfg_latch
    import pcd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LATCH_W-1:0] wdata,
    output logic [LATCH_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> q == $past(wdata));

    // R1
    latch_reset_chk: assert property (@(posedge clk)
        rst |=> q == '0);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/pcd_route_builder.sv
module pcd_route_builder
    import pcd_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  kind_e              kind,
    input  logic [15:0]        port16,
    input  logic               is_write,
    input  logic [LATCH_W-1:0] latch_q,
    output route_t             route,
    output logic [PA_W-1:0]    addr
);
    localparam logic [PA_W-1:0] CFGSPC_BASE = PA_W'(1) << (PA_W-1);
    localparam logic [PA_W-1:0] GENIO_BASE  = PA_W'(1) << (PA_W-2);

    always_comb begin
        route = '{region: RG_NONE, err: 1'b0, unclaimed: 1'b0, rdata: '0};
        addr  = '0;
        case (kind)
            K_BADPORT: route.err = 1'b1;
            K_LATCH: begin
                route.region = RG_LATCH;
                if (!is_write)
                    route.rdata = latch_q;
            end
            K_WINDOW: begin
                if (latch_q[EN_BIT]) begin
                    route.region = RG_CFGSPC;
                    addr = CFGSPC_BASE | PA_W'(latch_q[EN_BIT-1:0]);
                end else begin
                    route.unclaimed = 1'b1;
                    if (!is_write)
                        route.rdata = '1;
                end
            end
            default: begin
                route.region = RG_GENIO;
                addr = GENIO_BASE | PA_W'(port16);
            end
        endcase
    end

endmodule

// File: rtl/pci_port_decoder.sv
module pci_port_decoder
    import pcd_pkg::*;
#(
    parameter int PORT_IN_W = 32,
    parameter int PA_W      = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic [PORT_IN_W-1:0] acc_port,
    input  logic [2:0]           acc_size,
    input  logic                 acc_write,
    input  logic [31:0]          acc_wdata,
    output logic                 out_valid,
    output logic [1:0]           out_region,
    output logic [PA_W-1:0]      out_addr,
    output logic [31:0]          out_rdata,
    output logic                 out_err,
    output logic                 out_unclaimed
);
    kind_e              kind;
    logic [15:0]        port16;
    logic [LATCH_W-1:0] latch_q;
    logic               latch_wr;
    route_t             route;
    logic [PA_W-1:0]    route_addr;

    pcd_port_classifier #(.PORT_IN_W(PORT_IN_W)) u_classify (
        .port_in (acc_port),
        .size_in (acc_size),
        .kind    (kind),
        .port16  (port16)
    );

    assign latch_wr = acc_valid && acc_write && kind == K_LATCH;

    pcd_cfg_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .wr_en (latch_wr),
        .wdata (acc_wdata),
        .q     (latch_q)
    );

    pcd_route_builder #(.PA_W(PA_W)) u_route (
        .kind     (kind),
        .port16   (port16),
        .is_write (acc_write),
        .latch_q  (latch_q),
        .route    (route),
        .addr     (route_addr)
    );

    always_ff @(posedge clk) begin
        if (rst || !acc_valid) begin
            out_valid     <= 1'b0;
            out_region    <= RG_NONE;
            out_addr      <= '0;
            out_rdata     <= '0;
            out_err       <= 1'b0;
            out_unclaimed <= 1'b0;
        end else begin
            out_valid     <= 1'b1;
            out_region    <= route.region;
            out_addr      <= route_addr;
            out_rdata     <= route.rdata;
            out_err       <= route.err;
            out_unclaimed <= route.unclaimed;
        end
    end

    // R2
    wide_port_err_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && ((acc_port >> 16) != '0) |=> out_valid && out_err);

    // R8
    idle_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !out_valid);

    // R9
    class_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_err, out_unclaimed, out_region != RG_NONE}));

    // R6
    unclaimed_ones_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && hits_window(port16) && !latch_q[EN_BIT]
            && ((acc_port >> 16) == '0) |=> out_rdata == '1);

    // R5
    cfgspc_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && out_region == RG_CFGSPC |-> $past(latch_q[EN_BIT]));

endmodule

// File: tb/test_pci_port_decoder.sv
`timescale 1ns/1ps
module test_pci_port_decoder;
    localparam int PORT_IN_W = 32;
    localparam int PA_W      = 40;
    localparam logic [PA_W-1:0] CFG_BASE = PA_W'(1) << (PA_W-1);
    localparam logic [PA_W-1:0] IO_BASE  = PA_W'(1) << (PA_W-2);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 acc_valid = 1'b0;
    logic [PORT_IN_W-1:0] acc_port = '0;
    logic [2:0]           acc_size = 3'd0;
    logic                 acc_write = 1'b0;
    logic [31:0]          acc_wdata = '0;
    logic                 out_valid;
    logic [1:0]           out_region;
    logic [PA_W-1:0]      out_addr;
    logic [31:0]          out_rdata;
    logic                 out_err;
    logic                 out_unclaimed;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = '0;

    always #2.5 clk = ~clk;

    pci_port_decoder #(.PORT_IN_W(PORT_IN_W), .PA_W(PA_W)) i_pci_port_decoder (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_port(acc_port),
        .acc_size(acc_size), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .out_valid(out_valid), .out_region(out_region), .out_addr(out_addr),
        .out_rdata(out_rdata), .out_err(out_err), .out_unclaimed(out_unclaimed)
    );

    task automatic cmp(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s port=%h actual=%h expected=%h",
                     req, what, acc_port, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] port, input logic [2:0] sz,
                          input logic wr, input logic [31:0] wd);
        logic [1:0]      e_reg = 2'd0;
        logic [PA_W-1:0] e_addr = '0;
        logic [31:0]     e_rd = '0;
        logic            e_err = 1'b0;
        logic            e_unc = 1'b0;
        string           req;
        @(negedge clk);
        acc_valid = 1'b1; acc_port = port; acc_size = sz;
        acc_write = wr;   acc_wdata = wd;
        if (port > 32'hFFFF) begin
            req = "R2"; e_err = 1'b1;
        end else if (port == 32'hCF8 && sz == 3'd4) begin
            req = "R3"; e_reg = 2'd1;
            if (!wr) e_rd = model;
        end else if (port >= 32'hCFC && port <= 32'hCFF) begin
            if (model[31]) begin
                req = "R5"; e_reg = 2'd2;
                e_addr = CFG_BASE + PA_W'(model % 32'h8000_0000);
            end else begin
                req = "R6"; e_unc = 1'b1;
                if (!wr) e_rd = 32'hFFFF_FFFF;
            end
        end else begin
            req = (port == 32'hCF8) ? "R4" : "R7";
            e_reg = 2'd3;
            e_addr = IO_BASE + PA_W'(port);
        end
        if (port == 32'hCF8 && sz == 3'd4 && wr) model = wd;
        @(negedge clk);
        cmp(req, "valid",  64'(out_valid), 64'd1);
        cmp(req, "region", 64'(out_region), 64'(e_reg));
        cmp(req, "addr",   64'(out_addr), 64'(e_addr));
        cmp(req, "rdata",  64'(out_rdata), 64'(e_rd));
        cmp(req, "err",    64'(out_err), 64'(e_err));
        cmp(req, "unclaimed", 64'(out_unclaimed), 64'(e_unc));
        // R9: at most one class active
        cmp("R9", "classes", 64'(int'(out_err) + int'(out_unclaimed) + int'(out_region != 0) <= 1), 64'd1);
    endtask

    initial begin
        #950000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle outputs after reset
        cmp("R1", "valid", 64'(out_valid), 64'd0);
        cmp("R1", "region", 64'(out_region), 64'd0);
        cmp("R1", "addr", 64'(out_addr), 64'd0);
        cmp("R1", "flags", 64'({out_err, out_unclaimed}), 64'd0);
        access(32'hCF8, 3'd4, 1'b0, 32'h0);      // R1 latch reads zero
        access(32'hCFE, 3'd1, 1'b0, 32'h0);      // R6 disabled window
        access(32'hCF8, 3'd4, 1'b1, 32'h8012_3456);
        for (int p = 32'hCFC; p <= 32'hCFF; p++)  // R5 low bits ignored
            access(32'(p), 3'd2, 1'b0, 32'h0);
        access(32'hCFD, 3'd4, 1'b1, 32'hDEAD_BEEF); // R5 window write, latch kept
        access(32'hCF8, 3'd4, 1'b0, 32'h0);
        for (int s = 1; s <= 2; s++)              // R4 narrow latch port
            access(32'hCF8, 3'(s), 1'b1, 32'h0000_0001);
        access(32'hCF8, 3'd4, 1'b0, 32'h0);
        access(32'hCF8, 3'd4, 1'b1, 32'h7FFF_FFFF); // R6 enable clear
        access(32'hCFC, 3'd4, 1'b1, 32'h8000_0000);
        access(32'hCF8, 3'd4, 1'b0, 32'h0);
        // R8: idle cycle with latch write pattern on other inputs
        @(negedge clk);
        acc_valid = 1'b0; acc_port = 32'hCF8; acc_size = 3'd4;
        acc_write = 1'b1; acc_wdata = 32'h1111_1111;
        @(negedge clk);
        cmp("R8", "idle valid", 64'(out_valid), 64'd0);
        access(32'hCF8, 3'd4, 1'b0, 32'h0);      // R8 latch untouched
        // R2: each high bit alone
        for (int b = 16; b < 32; b++)
            access(32'h0000_0CF8 | (32'd1 << b), 3'd4, 1'b1, 32'hFFFF_FFFF);
        access(32'hCF8, 3'd4, 1'b0, 32'h0);
        // near-exhaustive sweep around the config ports
        for (int s = 0; s < 3; s++)
            for (int w = 0; w < 2; w++)
                for (int p = 32'hC00; p < 32'hE00; p++)
                    access(32'(p), 3'(1 << s), 1'(w),
                           32'h8000_0000 ^ (32'(p) * 32'h9E37_79B9));
        // R7: stride over full 16-bit space
        for (int p = 0; p < 32'h10000; p += 7)
            access(32'(p), 3'd2, 1'b0, 32'h0);
        access(32'hFFFF, 3'd1, 1'b0, 32'h0);
        @(negedge clk);
        acc_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule